// File: doc/BRIEF.md
# System Control Register Bank

This block is a small memory-mapped register bank on a 32-bit register bus with a 12-bit byte address and separate read and write strobes. It holds the user LED outputs, an optional debug-control word and a general control word that other board logic may use, and it presents the state of the push-button inputs and, optionally, the switch inputs. It also keeps two free-running time counters that count slow ticks. Each counter advances on its own one-cycle tick-enable pulse, one pulse per second and the other one pulse per 10 ms. Software can preload either counter and counting continues from the loaded value.

Three further addresses belong to a separate prescaled counter block. This bank only recognises those addresses. It forwards the access strobes with a two-bit selector, and it returns that block's read data on the bus. Read data is registered: a read issued in one cycle shows on the read-data output in the next cycle and stays there until the next read. The bank never reports a bus error. An offset that is not mapped reads as zero and ignores writes.

Top module: `sysctl_regbank`

## Requirements
- R1: Synchronous active-high reset clears the LED register, the control word, the debug word, both time counters and the read-data output to zero.
- R2: A write to offset 0x000 stores only the low NUM_LEDS bits of the write data, and each stored bit i drives led_out[i] high when set. A read of 0x000 returns the stored bits zero-extended.
- R3: Offset 0x04C is read/write storage. It reads back the last written value, and that value is also driven on misc_out.
- R4: When HAS_DBG is 1, offset 0x004 is read/write storage that is also driven on dbg_out. When HAS_DBG is 0, it behaves as an unmapped offset.
- R5: A read of offset 0x008 returns btn_in zero-extended. A write there changes nothing.
- R6: When HAS_SW is 1, a read of offset 0x028 returns sw_in zero-extended. When HAS_SW is 0, it behaves as an unmapped offset. Writes never change state.
- R7: Any offset without a register reads as zero, and writes to it leave every output and every register unchanged. Only exact 12-bit address matches select a register.
- R8: The counter at offset 0x010 adds one in each cycle where tick_1hz is high, and the counter at 0x014 does the same on tick_100hz. Both wrap from 0xFFFFFFFF to 0.
- R9: A write to 0x010 or 0x014 loads the written value. If a tick arrives in the same cycle, the write wins and the tick is lost.
- R10: Offsets 0x018, 0x01C and 0x020 raise fwd_rd or fwd_wr in the same cycle as the bus strobe, with fwd_sel equal to 0, 1 and 2 respectively. A read there returns fwd_rdata as sampled in the read cycle.
- R11: bus_rdata takes the value of the addressed register one cycle after bus_rd and holds it in cycles without a read. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data (also forwarded to the prescaled counter block) |
| bus_rdata | output | 32 | Registered read data |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_100hz | input | 1 | One-cycle pulse per 10 ms |
| btn_in | input | BTN_W | Push-button levels |
| sw_in | input | SW_W | Switch levels |
| led_out | output | NUM_LEDS | LED drives, active high |
| misc_out | output | 32 | General control word |
| dbg_out | output | 32 | Debug-control word |
| fwd_sel | output | 2 | Prescaled counter register select |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_rd | output | 1 | Forwarded read strobe |
| fwd_rdata | input | 32 | Read data from the prescaled counter block |

## Verification
A broken address decode shows at the ports in the same cycle for forwarded strobes and on the level outputs. It shows one cycle later on bus_rdata, as a register that answers at the wrong offset or an unmapped offset that reads non-zero. A time counter that misses a tick or drops a load stays hidden until the next read of it, so the bench reads the counters right after single ticks, after bursts and at the wrap point. The bench compares every output against its model on every clock, so any corrupted stored word shows within a cycle on the level outputs, or in the cycle after the read that reaches it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_LED    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_DBG    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_BTN    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CENTI  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_PCOUNT = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_PRELD  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_PCUR   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SW     = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_MISC   = 12'h04C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_DBG,
        SEL_BTN,
        SEL_SEC,
        SEL_CENTI,
        SEL_PCOUNT,
        SEL_PRELD,
        SEL_PCUR,
        SEL_SW,
        SEL_MISC
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } bus_req_t;

    function automatic logic is_fwd(input reg_sel_e s);
        return (s == SEL_PCOUNT) || (s == SEL_PRELD) || (s == SEL_PCUR);
    endfunction

    function automatic logic [1:0] fwd_index(input reg_sel_e s);
        case (s)
            SEL_PRELD: return 2'd1;
            SEL_PCUR:  return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter bit HAS_DBG = 1'b1,
    parameter bit HAS_SW  = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        case (addr)
            OFS_LED:    sel = SEL_LED;
            OFS_DBG:    sel = HAS_DBG ? SEL_DBG : SEL_NONE;
            OFS_BTN:    sel = SEL_BTN;
            OFS_SEC:    sel = SEL_SEC;
            OFS_CENTI:  sel = SEL_CENTI;
            OFS_PCOUNT: sel = SEL_PCOUNT;
            OFS_PRELD:  sel = SEL_PRELD;
            OFS_PCUR:   sel = SEL_PCUR;
            OFS_SW:     sel = HAS_SW ? SEL_SW : SEL_NONE;
            OFS_MISC:   sel = SEL_MISC;
            default:    sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sysctl_timecnt.sv
module sysctl_timecnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)        count <= '0;
        else if (load)  count <= load_val;
        else if (tick)  count <= count + 1'b1;
    end

    // R8
    tick_adds_one_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (count == $past(count) + 1'b1));

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 2,
    parameter int unsigned BTN_W    = 4,
    parameter int unsigned SW_W     = 8,
    parameter bit          HAS_DBG  = 1'b1,
    parameter bit          HAS_SW   = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [11:0]         bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                tick_1hz,
    input  logic                tick_100hz,
    input  logic [BTN_W-1:0]    btn_in,
    input  logic [SW_W-1:0]     sw_in,
    output logic [NUM_LEDS-1:0] led_out,
    output logic [31:0]         misc_out,
    output logic [31:0]         dbg_out,
    output logic [1:0]          fwd_sel,
    output logic                fwd_wr,
    output logic                fwd_rd,
    input  logic [31:0]         fwd_rdata
);
    localparam int unsigned N_TIMERS = 2;

    if (NUM_LEDS < 1 || NUM_LEDS > DATA_W) begin : g_led_bound
        $error("NUM_LEDS must lie in 1..32");
    end

    reg_sel_e  sel;
    bus_req_t  req;

    sysctl_decode #(.HAS_DBG(HAS_DBG), .HAS_SW(HAS_SW)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign req = '{sel: sel, wr: bus_wr, rd: bus_rd};

    // Time counters: index 0 counts seconds, index 1 counts hundredths
    logic [N_TIMERS-1:0]  tmr_tick;
    logic [N_TIMERS-1:0]  tmr_load;
    logic [DATA_W-1:0]    tmr_val [N_TIMERS];

    assign tmr_tick = {tick_100hz, tick_1hz};
    assign tmr_load = {req.wr && (req.sel == SEL_CENTI),
                       req.wr && (req.sel == SEL_SEC)};

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        sysctl_timecnt #(.W(DATA_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .tick     (tmr_tick[g]),
            .load     (tmr_load[g]),
            .load_val (bus_wdata),
            .count    (tmr_val[g])
        );
    end

    // Stored words
    always_ff @(posedge clk) begin
        if (rst) begin
            led_out  <= '0;
            misc_out <= '0;
            dbg_out  <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_LED:  led_out  <= bus_wdata[NUM_LEDS-1:0];
                SEL_MISC: misc_out <= bus_wdata;
                SEL_DBG:  dbg_out  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Forwarding to the prescaled counter block
    assign fwd_sel = fwd_index(req.sel);
    assign fwd_wr  = req.wr && is_fwd(req.sel);
    assign fwd_rd  = req.rd && is_fwd(req.sel);

    // Read path
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        case (req.sel)
            SEL_LED:    rd_mux = DATA_W'(led_out);
            SEL_DBG:    rd_mux = dbg_out;
            SEL_BTN:    rd_mux = DATA_W'(btn_in);
            SEL_SEC:    rd_mux = tmr_val[0];
            SEL_CENTI:  rd_mux = tmr_val[1];
            SEL_PCOUNT,
            SEL_PRELD,
            SEL_PCUR:   rd_mux = fwd_rdata;
            SEL_SW:     rd_mux = DATA_W'(sw_in);
            SEL_MISC:   rd_mux = misc_out;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (req.rd) bus_rdata <= rd_mux;
    end

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R2
    led_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LED) |=> (led_out == $past(bus_wdata[NUM_LEDS-1:0])));

    // R3
    misc_store_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_MISC) |=> (misc_out == $past(bus_wdata)));

    // R7
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_NONE) |=> ($stable(led_out) && $stable(misc_out) && $stable(dbg_out)));

    // R10
    fwd_read_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_rd |=> (bus_rdata == $past(fwd_rdata)));

    // R10
    fwd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(fwd_wr && fwd_rd && !(bus_wr && bus_rd)));
endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int BW = 4;
    localparam int SWW = 8;
    localparam bit HD = 1'b1;
    localparam bit HS = 1'b0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tick_1hz = 1'b0, tick_100hz = 1'b0;
    logic [BW-1:0] btn_in = 4'b1010;
    logic [SWW-1:0] sw_in = 8'hFF;
    logic [NL-1:0] led_out;
    logic [31:0] misc_out, dbg_out;
    logic [1:0] fwd_sel;
    logic fwd_wr, fwd_rd;
    logic [31:0] fwd_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regbank #(.NUM_LEDS(NL), .BTN_W(BW), .SW_W(SWW), .HAS_DBG(HD), .HAS_SW(HS))
    u_sysctl_regbank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1hz(tick_1hz),
        .tick_100hz(tick_100hz), .btn_in(btn_in), .sw_in(sw_in), .led_out(led_out),
        .misc_out(misc_out), .dbg_out(dbg_out), .fwd_sel(fwd_sel), .fwd_wr(fwd_wr),
        .fwd_rd(fwd_rd), .fwd_rdata(fwd_rdata)
    );

    assign fwd_rdata = 32'hC0DE_0000 | {20'd0, bus_addr};

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    longint m_led, m_misc, m_dbg, m_sec, m_centi, m_rdata;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint mread(input int a);
        case (a)
            'h000: return m_led;
            'h004: return HD ? m_dbg : 0;
            'h008: return longint'(btn_in);
            'h010: return m_sec;
            'h014: return m_centi;
            'h018, 'h01C, 'h020: return 64'hC0DE_0000 | a;
            'h028: return HS ? longint'(sw_in) : 0;
            'h04C: return m_misc;
            default: return 0;
        endcase
    endfunction

    task automatic cyc(input int a, input bit wr, input bit rd, input longint wd,
                       input bit t1, input bit t100);
        int fi;
        bit isf;
        bus_addr = 12'(a); bus_wr = wr; bus_rd = rd; bus_wdata = 32'(wd);
        tick_1hz = t1; tick_100hz = t100;
        #1;
        isf = (a == 'h018) || (a == 'h01C) || (a == 'h020);
        fi = (a == 'h01C) ? 1 : (a == 'h020) ? 2 : 0;
        if (!rst) begin
            chk("R10", fwd_rd, rd && isf);
            chk("R10", fwd_wr, wr && isf);
            if (isf) chk("R10", fwd_sel, fi);
        end
        @(posedge clk);
        @(negedge clk);
        if (rst) begin
            m_led = 0; m_misc = 0; m_dbg = 0; m_sec = 0; m_centi = 0; m_rdata = 0;
        end else begin
            if (rd) m_rdata = mread(a);
            if (wr && a == 'h000) m_led = wd & ((64'd1 << NL) - 1);
            if (wr && a == 'h04C) m_misc = wd & 32'hFFFF_FFFF;
            if (wr && a == 'h004 && HD) m_dbg = wd & 32'hFFFF_FFFF;
            if (wr && a == 'h010) m_sec = wd & 32'hFFFF_FFFF;
            else if (t1) m_sec = (m_sec + 1) & 32'hFFFF_FFFF;
            if (wr && a == 'h014) m_centi = wd & 32'hFFFF_FFFF;
            else if (t100) m_centi = (m_centi + 1) & 32'hFFFF_FFFF;
        end
        chk(cur_req, led_out, m_led);
        chk(cur_req, misc_out, m_misc);
        chk(cur_req, dbg_out, m_dbg);
        chk(cur_req, bus_rdata, m_rdata);
    endtask

    task automatic wr_reg(input int a, input longint d); cyc(a, 1, 0, d, 0, 0); endtask
    task automatic rd_reg(input int a); cyc(a, 0, 1, 0, 0, 0); endtask
    task automatic idle(); cyc('h3FC, 0, 0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        rst = 1'b1;
        repeat (3) cyc('h000, 0, 0, 0, 0, 0);
        rst = 1'b0;
        rd_reg('h010); rd_reg('h014); rd_reg('h000); rd_reg('h04C);

        cur_req = "R2";
        wr_reg('h000, 64'hFFFF_FFFF); rd_reg('h000);
        wr_reg('h000, 64'h0000_0002); rd_reg('h000);
        wr_reg('h000, 64'h8000_0005); rd_reg('h000);

        cur_req = "R3";
        wr_reg('h04C, 64'hA5A5_1234); rd_reg('h04C);
        wr_reg('h04C, 64'h0F0F_F0F0); rd_reg('h04C);

        cur_req = "R4";
        wr_reg('h004, 64'hDEAD_BEEF); rd_reg('h004);

        cur_req = "R5";
        rd_reg('h008);
        btn_in = 4'b0110; rd_reg('h008);
        wr_reg('h008, 64'hFFFF_FFFF); rd_reg('h008);

        cur_req = "R6";
        rd_reg('h028); wr_reg('h028, 64'h1234_5678); rd_reg('h028);

        cur_req = "R7";
        wr_reg('h030, 64'hFFFF_FFFF); rd_reg('h030);
        wr_reg('h001, 64'hFFFF_FFFF); rd_reg('h001);
        wr_reg('hFFC, 64'h5555_5555); rd_reg('hFFC);
        wr_reg('h04D, 64'h0); rd_reg('h04C); rd_reg('h000);

        cur_req = "R8";
        for (int i = 0; i < 5; i++) begin
            cyc('h3FC, 0, 0, 0, 1, 1);
            cyc('h3FC, 0, 0, 0, 0, 1);
        end
        rd_reg('h010); rd_reg('h014);
        cyc('h010, 0, 1, 0, 1, 0);
        rd_reg('h010);
        wr_reg('h010, 64'hFFFF_FFFF);
        cyc('h3FC, 0, 0, 0, 1, 0);
        rd_reg('h010);
        wr_reg('h014, 64'hFFFF_FFFE);
        cyc('h3FC, 0, 0, 0, 0, 1); cyc('h3FC, 0, 0, 0, 0, 1);
        rd_reg('h014);

        cur_req = "R9";
        cyc('h010, 1, 0, 64'h0000_0100, 1, 1);
        rd_reg('h010); rd_reg('h014);
        cyc('h014, 1, 0, 64'h0000_0777, 1, 1);
        rd_reg('h014); rd_reg('h010);
        cyc('h3FC, 0, 0, 0, 1, 1);
        rd_reg('h010); rd_reg('h014);

        cur_req = "R10";
        rd_reg('h018); rd_reg('h01C); rd_reg('h020);
        wr_reg('h018, 64'h11); wr_reg('h01C, 64'h22); wr_reg('h020, 64'h33);
        idle();

        cur_req = "R11";
        rd_reg('h04C); idle(); idle();
        cyc('h04C, 1, 1, 64'hCAFE_F00D, 0, 0);
        rd_reg('h04C);
        cyc('h010, 1, 1, 64'h4242_0000, 0, 0);
        rd_reg('h010); idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule